// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block keeps a small set of recent virtual-to-physical page translations. Every stored entry is compared with the request at the same time. A lookup supplies a 20-bit virtual page number, a process identifier, the access kind (read or write) and the privilege of the requester (user or kernel). The same cycle, with no clock edge in between, the block returns a hit flag, the 18-bit physical page number, the stored dirty state of the entry that matched, and a flag that reports an access the entry does not permit.

Each entry carries the identifier of the process that owns it. A context switch therefore leaves the other processes' translations in place, and they can still hit later. When a miss has been resolved elsewhere, the refill port installs the translation. A refill first takes an empty slot. When every slot is full, a use-bit approximation of least-recently-used picks the victim. Two flush controls act on the next clock edge. One invalidates every entry. The other invalidates only the entries of one process identifier. Walking the page tables and accessing the data cache are left to other blocks.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup returns lk_hit=0, lk_fault=0, lk_dirty=0 and lk_ppn=0.
- R2: With lk_en=1, lk_hit is 1 exactly when a valid entry matches both lk_vpn and lk_asid. In that case lk_ppn carries that entry's physical page number in the same cycle, before any clock edge.
- R3: lk_fault is 1 on a hit when any of these holds: the requester is user mode (lk_user=1) and the entry is kernel-only (user bit 0); it is a write (lk_write=1) and the write bit is 0; it is a read (lk_write=0) and the read bit is 0. lk_fault is never 1 without a hit.
- R4: lk_dirty reports the dirty bit that the hit entry holds before the access. A write hit without a fault sets that bit at the clock edge.
- R5: Every enabled hit, and every refill, sets the use bit of its entry. If this would leave every use bit set, all the other use bits are cleared.
- R6: A refill whose page and identifier are not already present goes into the lowest-numbered invalid entry. The new entry starts with its dirty bit cleared.
- R7: When all entries are valid, such a refill replaces the lowest-numbered entry whose use bit is clear.
- R8: A refill whose page and identifier are already present rewrites that entry in place, with the new physical page and permissions and its dirty bit cleared. No duplicate entry is created.
- R9: When fl_asid_en=1, every entry whose identifier equals fl_asid becomes invalid at the next edge. Entries of other identifiers keep their valid bits.
- R10: When fl_all=1, every entry becomes invalid at the next edge.
- R11: A refill in the same cycle as either flush is dropped.
- R12: With lk_en=0 all lookup outputs are 0, and the lookup changes neither the dirty bits nor the use bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request valid |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup process identifier |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | 18 | Physical page number of the hit |
| lk_fault | output | 1 | Permission violation on the hit |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this access |
| rf_en | input | 1 | Refill request |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 8 | Refill process identifier |
| rf_ppn | input | 18 | Refill physical page number |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_usr | input | 1 | Refill user-accessible bit |
| fl_all | input | 1 | Invalidate every entry |
| fl_asid_en | input | 1 | Invalidate the entries of fl_asid |
| fl_asid | input | 8 | Identifier to flush |

## Verification
The array is filled with 32 translations spread over four identifiers and a mix of permission bits. Lookups then sweep every page against every identifier, both access kinds and both privilege modes. This separates a correct identifier compare from a compare on the page number alone, and it separates each of the three permission conditions from the others. Repeated writes to the same page show the dirty bit as it was before each access, and a write with the lookup disabled shows that it left no trace. Refills into the full array, followed by full sweeps, show which entry the use bits chose as the victim. In-place rewrites, a flush by identifier, a flush that collides with a refill, and a full flush are each followed by sweeps that show exactly which translations remain.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
  } perm_t;

  // violation rule applied to the hit entry
  function automatic logic perm_fault(perm_t p, logic is_wr, logic is_usr);
    return (is_usr && !p.usr) || (is_wr && !p.wr) || (!is_wr && !p.rd);
  endfunction

  // use-bit update: set the touched bits; if all would be set, keep only the touched ones
  function automatic logic [255:0] use_next(logic [255:0] cur, logic [255:0] touch,
                                            logic [255:0] live);
    logic [255:0] merged;
    merged = (cur | touch) & live;
    return (merged == live) ? touch : merged;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] tag_asid,
  input  logic                           vpn_care,
  input  logic [VPN_W-1:0]               q_vpn,
  input  logic [ASID_W-1:0]              q_asid,
  output logic [ENTRIES-1:0]             match
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic asid_eq, vpn_eq;
    assign asid_eq  = (tag_asid[e] == q_asid);
    assign vpn_eq   = (tag_vpn[e] == q_vpn) || !vpn_care;
    assign match[e] = valid[e] && asid_eq && vpn_eq;
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] used,
  output logic [IDX_W-1:0]   victim_idx
);
  logic             has_free;
  logic [IDX_W-1:0] free_idx, cold_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    cold_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid[e]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(e);
      end
      if (!used[e]) cold_idx = IDX_W'(e);
    end
  end

  assign victim_idx = has_free ? free_idx : cold_idx;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_fault,
  output logic              lk_dirty,
  input  logic              rf_en,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic              rf_rd,
  input  logic              rf_wr,
  input  logic              rf_usr,
  input  logic              fl_all,
  input  logic              fl_asid_en,
  input  logic [ASID_W-1:0] fl_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  // entry storage
  logic [ENTRIES-1:0]             valid_q, use_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  perm_t [ENTRIES-1:0]            perm_q;

  // named internal events
  logic [ENTRIES-1:0] lk_match, hit_vec, rf_match, fl_match;
  logic [ENTRIES-1:0] rf_oh, flush_mask, dirty_set;
  logic [ENTRIES-1:0] valid_nx, use_nx, dirty_nx;
  logic [IDX_W-1:0]   vic_idx, rf_old_idx, rf_idx;
  logic               rf_write;

  logic [PPN_W-1:0] sel_ppn;
  perm_t            sel_perm;
  logic             sel_dirty;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q), .vpn_care(1'b1),
    .q_vpn(lk_vpn), .q_asid(lk_asid), .match(lk_match));

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q), .vpn_care(1'b1),
    .q_vpn(rf_vpn), .q_asid(rf_asid), .match(rf_match));

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q), .vpn_care(1'b0),
    .q_vpn(lk_vpn), .q_asid(fl_asid), .match(fl_match));

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .used(use_q), .victim_idx(vic_idx));

  // lookup path, purely combinational
  assign hit_vec = lk_en ? lk_match : '0;

  always_comb begin
    sel_ppn   = '0;
    sel_perm  = '0;
    sel_dirty = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e]) begin
        sel_ppn   = sel_ppn | ppn_q[e];
        sel_perm  = perm_t'(sel_perm | perm_q[e]);
        sel_dirty = sel_dirty | dirty_q[e];
      end
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_ppn   = sel_ppn;
  assign lk_fault = lk_hit && perm_fault(sel_perm, lk_write, lk_user);
  assign lk_dirty = lk_hit && sel_dirty;

  // refill slot selection
  always_comb begin
    rf_old_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rf_match[e]) rf_old_idx = IDX_W'(e);
    end
  end

  assign rf_write = rf_en && !fl_all && !fl_asid_en;
  assign rf_idx   = (|rf_match) ? rf_old_idx : vic_idx;
  assign rf_oh    = rf_write ? (ENTRIES'(1) << rf_idx) : '0;

  // state update vectors
  assign flush_mask = fl_all ? '1 : (fl_asid_en ? fl_match : '0);
  assign dirty_set  = (lk_hit && lk_write && !lk_fault) ? hit_vec : '0;
  assign valid_nx   = (valid_q | rf_oh) & ~flush_mask;
  assign dirty_nx   = (dirty_q | dirty_set) & ~rf_oh;
  assign use_nx     = ENTRIES'(use_next(256'(use_q), 256'(hit_vec | rf_oh),
                                        256'({ENTRIES{1'b1}})));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      use_q   <= '0;
      dirty_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
    end else begin
      valid_q <= valid_nx;
      use_q   <= use_nx;
      dirty_q <= dirty_nx;
      for (int e = 0; e < ENTRIES; e++) begin
        if (rf_oh[e]) begin
          vpn_q[e]  <= rf_vpn;
          asid_q[e] <= rf_asid;
          ppn_q[e]  <= rf_ppn;
          perm_q[e] <= '{rd: rf_rd, wr: rf_wr, usr: rf_usr};
        end
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic               lk_write,
  input logic               fl_all,
  input logic               fl_asid_en,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] use_q,
  input logic [ENTRIES-1:0] dirty_q,
  input logic [ENTRIES-1:0] rf_oh,
  input logic [ENTRIES-1:0] flush_mask
);
  p_fault_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  p_no_duplicate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_dirty_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !lk_fault && rf_oh == '0) |=> (dirty_q & $past(hit_vec)) != '0);

  p_use_never_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_q != '1);

  p_refill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_oh != '0) |=> (valid_q & $past(rf_oh)) == $past(rf_oh));

  p_flush_asid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_asid_en && !fl_all) |=> (valid_q & $past(flush_mask)) == '0);

  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> valid_q == '0);

  p_flush_drops_refill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all || fl_asid_en) |=> $countones(valid_q) <= $past($countones(valid_q)));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_write(lk_write),
  .fl_all(fl_all), .fl_asid_en(fl_asid_en), .hit_vec(hit_vec), .valid_q(valid_q),
  .use_q(use_q), .dirty_q(dirty_q), .rf_oh(rf_oh), .flush_mask(flush_mask));

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en, lk_write, lk_user, rf_en, rf_rd, rf_wr, rf_usr, fl_all, fl_asid_en;
  logic [19:0] lk_vpn, rf_vpn;
  logic [7:0]  lk_asid, rf_asid, fl_asid;
  logic [17:0] rf_ppn, lk_ppn;
  logic        lk_hit, lk_fault, lk_dirty;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic        m_v[N], m_use[N], m_d[N], m_r[N], m_w[N], m_u[N];
  logic [19:0] m_vpn[N];
  logic [7:0]  m_asid[N];
  logic [17:0] m_ppn[N];

  xlat_cache dut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_en = 0; lk_write = 0; lk_user = 0; lk_vpn = 0; lk_asid = 0;
    rf_en = 0; rf_rd = 0; rf_wr = 0; rf_usr = 0; rf_vpn = 0; rf_asid = 0; rf_ppn = 0;
    fl_all = 0; fl_asid_en = 0; fl_asid = 0;
  endtask

  function automatic int m_find(logic [19:0] v, logic [7:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
    return -1;
  endfunction

  function automatic void m_touch(int k);
    int ones = 0;
    m_use[k] = 1;
    for (int i = 0; i < N; i++) ones += int'(m_use[i]);
    if (ones == N) begin
      for (int i = 0; i < N; i++) m_use[i] = 0;
      m_use[k] = 1;
    end
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_use[i]) return i;
    return 0;
  endfunction

  task automatic look(logic [19:0] v, logic [7:0] a, logic wr, logic usr, logic en, string tag);
    int k;
    logic eh, ef, ed;
    logic [17:0] ep;
    @(negedge clk);
    idle();
    lk_en = en; lk_vpn = v; lk_asid = a; lk_write = wr; lk_user = usr;
    #5;
    k  = en ? m_find(v, a) : -1;
    eh = (k >= 0);
    ep = eh ? m_ppn[k] : '0;
    ef = eh && ((usr && !m_u[k]) || (wr && !m_w[k]) || (!wr && !m_r[k]));
    ed = eh && m_d[k];
    chk({tag, " R2 hit"}, 32'(lk_hit), 32'(eh));
    chk({tag, " R2 ppn"}, 32'(lk_ppn), 32'(ep));
    chk({tag, " R3 fault"}, 32'(lk_fault), 32'(ef));
    chk({tag, " R4 dirty"}, 32'(lk_dirty), 32'(ed));
    @(posedge clk);
    if (eh) begin
      m_touch(k);
      if (wr && !ef) m_d[k] = 1;
    end
  endtask

  task automatic refill(logic [19:0] v, logic [7:0] a, logic [17:0] p, logic r, logic w,
                        logic u, logic fa, logic fe, logic [7:0] fid);
    int k;
    @(negedge clk);
    idle();
    rf_en = 1; rf_vpn = v; rf_asid = a; rf_ppn = p; rf_rd = r; rf_wr = w; rf_usr = u;
    fl_all = fa; fl_asid_en = fe; fl_asid = fid;
    @(posedge clk);
    if (!fa && !fe) begin
      k = m_find(v, a);
      if (k < 0) k = m_victim();
      m_v[k] = 1; m_vpn[k] = v; m_asid[k] = a; m_ppn[k] = p;
      m_r[k] = r; m_w[k] = w; m_u[k] = u; m_d[k] = 0;
      m_touch(k);
    end
    for (int i = 0; i < N; i++) if (fa || (fe && m_asid[i] == fid)) m_v[i] = 0;
  endtask

  task automatic flush(logic fa, logic fe, logic [7:0] fid);
    @(negedge clk);
    idle();
    fl_all = fa; fl_asid_en = fe; fl_asid = fid;
    @(posedge clk);
    for (int i = 0; i < N; i++) if (fa || (fe && m_asid[i] == fid)) m_v[i] = 0;
  endtask

  function automatic logic [19:0] pg(int i);
    return 20'(i * 37 + 5);
  endfunction

  task automatic sweep(int count, string tag);
    for (int i = 0; i < count; i++)
      for (int a = 0; a < 4; a++)
        for (int m = 0; m < 4; m++)
          look(pg(i), 8'(a), m[0], m[1], 1'b1, tag);
  endtask

  initial begin
    idle();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_use[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0; m_u[i] = 0;
      m_vpn[i] = 0; m_asid[i] = 0; m_ppn[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: empty after reset
    look(20'h5, 8'h0, 1'b0, 1'b0, 1'b1, "R1 reset");
    look(20'h0, 8'h0, 1'b1, 1'b1, 1'b1, "R1 reset");

    // R6: fill every slot, mixed identifiers and permissions
    for (int i = 0; i < N; i++)
      refill(pg(i), 8'(i % 4), 18'(i * 7 + 3), i[0] | i[1], i[1], i[2], 1'b0, 1'b0, 8'h0);
    sweep(N, "R6 fill");

    // R4: repeated writes to a writable user page (i=6: rd,wr,usr)
    look(pg(6), 8'(2), 1'b1, 1'b1, 1'b1, "R4 write");
    look(pg(6), 8'(2), 1'b0, 1'b1, 1'b1, "R4 readback");

    // R5 R7: refills into the full array use the use bits
    for (int j = 0; j < 8; j++) begin
      refill(pg(100 + j), 8'h5, 18'(j + 900), 1'b1, j[0], 1'b1, 1'b0, 1'b0, 8'h0);
      look(pg(j * 3), 8'(j * 3 % 4), 1'b0, 1'b0, 1'b1, "R5 touch");
    end
    sweep(N, "R7 evict");
    for (int j = 0; j < 8; j++) look(pg(100 + j), 8'h5, 1'b1, 1'b0, 1'b1, "R7 new");

    // R8: rewrite an existing translation in place
    refill(pg(101), 8'h5, 18'h2_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0);
    look(pg(101), 8'h5, 1'b1, 1'b0, 1'b1, "R8 rewrite");
    look(pg(101), 8'h5, 1'b0, 1'b0, 1'b1, "R8 rewrite");
    look(pg(101), 8'h5, 1'b1, 1'b1, 1'b1, "R8 rewrite");

    // R12: disabled lookup leaves no trace
    refill(pg(102), 8'h5, 18'h0_0777, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0);
    look(pg(102), 8'h5, 1'b1, 1'b0, 1'b0, "R12 disabled");
    look(pg(102), 8'h5, 1'b0, 1'b0, 1'b1, "R12 after");

    // R9: flush one identifier
    flush(1'b0, 1'b1, 8'h1);
    sweep(N, "R9 flush id");

    // R11: refill during a flush is dropped
    refill(pg(200), 8'h0, 18'h0_0abc, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3);
    look(pg(200), 8'h0, 1'b0, 1'b0, 1'b1, "R11 dropped");
    refill(pg(201), 8'h2, 18'h0_0abd, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0);
    look(pg(201), 8'h2, 1'b0, 1'b0, 1'b1, "R11 dropped");
    sweep(8, "R10 all");

    // R10: flush everything, then the array refills from slot 0 again
    refill(pg(300), 8'h7, 18'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
    flush(1'b1, 1'b0, 8'h0);
    sweep(N, "R10 all");
    look(pg(300), 8'h7, 1'b0, 1'b0, 1'b1, "R10 all");
    refill(pg(3), 8'h3, 18'h3_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
    sweep(4, "R6 refill");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule